// File: doc/BRIEF.md
# GPU Command Packet Parser

The block takes a stream of 32-bit command words, one per handshake, and groups them into whole command packets. The top byte of the first word of each packet is its opcode, and a length table indexed by that opcode tells how many parameter words follow. When the last word of a packet has arrived, the block sends the packet to a renderer on a word-wide valid/ready stream and marks the final word.

While it frames packets, the block tracks some state. It keeps a 13-bit status word, eight 32-bit environment registers and a sticky flag that records whether any drawing or memory-touching opcode has been seen. Image-transfer opcodes do not go to the renderer. Their position and size words go to a separate VRAM transfer engine as a one-cycle start pulse. While that engine is absorbing a write transfer, it holds `xfer_active` high, and input words pass straight through to it instead of to the parser.

Top module: `gpu_cmd_parser`

## Requirements
- R1: A packet is 1 + N words, where N is set by the opcode (bits 31:24 of the first word). N is 2 for 0x02. For 0x20-0x3F it depends on the low nibble group: 0x20-0x23 is 3, 0x24-0x27 is 6, 0x28-0x2B is 4, 0x2C-0x2F is 8, 0x30-0x33 is 5, 0x34-0x37 is 8, 0x38-0x3B is 7 and 0x3C-0x3F is 11. For 0x40-0x7F it is 2, 0, 3, 3 for 0x40, 0x44, 0x48, 0x4C; 3, 0, 4, 4 for 0x50, 0x54, 0x58, 0x5C; 2, 3, 1, 2 for 0x60-0x6F; and 1, 2, 1, 2 for 0x70-0x7F, each value covering four opcodes. N is 3 for 0x80, 2 for 0xA0 and 0xC0, and 0 for every other opcode. A forwarded packet leaves on `pkt_data` in arrival order, with `pkt_last` high only on its final word.
- R2: A packet is not offered on the output until its last word has been accepted. `pkt_valid` rises only in the cycle after an input word is accepted.
- R3: When the opcode masked with 0xF4 equals 0x24, status bits 8:0 take bits 8:0 of the packet's fifth word. When it equals 0x34, they take bits 8:0 of the sixth word.
- R4: Opcode 0xE1 copies its word bits 10:0 into status bits 10:0. Opcode 0xE6 copies its word bits 1:0 into status bits 12:11.
- R5: Every opcode 0xE0-0xE7 stores its full word in environment register (opcode & 7), which appears at `env_flat[32*k +: 32]`.
- R6: Opcodes 0xA0 (write) and 0xC0 (read) are never forwarded. One cycle after their third word is accepted, `xfer_start` pulses for one cycle. At that point `xfer_pos` holds the second word, `xfer_size` holds the third, and `xfer_read` is 1 only for 0xC0.
- R7: `dirty` becomes 1 once any packet with an opcode from 0x02 to 0xBF completes, and it stays 1 until reset. Other opcodes leave it unchanged.
- R8: While `xfer_active` is high, `in_ready` is 1 and each input word appears on `xfer_wdata` with `xfer_wvalid`. Such words never reach the parser. Parsing resumes with the first word after `xfer_active` falls.
- R9: A synchronous reset, active high, clears status, `dirty`, all environment registers and any partial packet, and leaves `pkt_valid` at 0.
- R10: While a packet is being sent out, `in_ready` is low unless `xfer_active` is high. A word held with `pkt_ready` low keeps `pkt_data` and `pkt_last` stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Command word valid |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Command word accepted when high with in_valid |
| pkt_valid | output | 1 | Renderer stream word valid |
| pkt_data | output | 32 | Renderer stream word |
| pkt_last | output | 1 | Final word of the packet |
| pkt_ready | input | 1 | Renderer accepts the word |
| xfer_active | input | 1 | Transfer engine is absorbing write data |
| xfer_wvalid | output | 1 | Write data word for the transfer engine |
| xfer_wdata | output | 32 | Write data word |
| xfer_start | output | 1 | One-cycle transfer start pulse |
| xfer_read | output | 1 | Transfer direction, 1 = read |
| xfer_pos | output | 32 | Transfer position word |
| xfer_size | output | 32 | Transfer size word |
| status | output | 13 | Snooped status bits |
| dirty | output | 1 | Sticky framebuffer-dirty flag |
| env_flat | output | 256 | Eight environment registers, register k at bits 32k+31:32k |

## Verification
The assertions assume that the transfer engine raises `xfer_active` no earlier than the cycle in which it sees a write `xfer_start`. They also assume it keeps the signal high only for the data words of that transfer, so no packet is being sent out while it is high. The bench's engine model follows this. It raises `xfer_active` in the start-pulse cycle, counts the low 16 bits of the size word as the number of data words, and drops the signal after the last one. Random packets are generated so that every write transfer is followed by exactly that many raw words.

// File: rtl/gpu_cmd_parser.sv
module gpu_cmd_parser #(
  parameter int MAX_WORDS = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [31:0]  in_data,
  output logic         in_ready,
  output logic         pkt_valid,
  output logic [31:0]  pkt_data,
  output logic         pkt_last,
  input  logic         pkt_ready,
  input  logic         xfer_active,
  output logic         xfer_wvalid,
  output logic [31:0]  xfer_wdata,
  output logic         xfer_start,
  output logic         xfer_read,
  output logic [31:0]  xfer_pos,
  output logic [31:0]  xfer_size,
  output logic [12:0]  status,
  output logic         dirty,
  output logic [255:0] env_flat
);
  localparam int IW    = $clog2(MAX_WORDS + 1);
  localparam int ENV_N = 8;

  typedef enum logic {COLLECT, EMIT} st_t;

  st_t          state;
  logic [31:0]  pkt_mem [MAX_WORDS];
  logic [31:0]  env_q [ENV_N];
  logic [IW-1:0] cnt, rd, len_q, cur_len;
  logic [7:0]   op_q, cur_op;
  logic         take, done;

  function automatic logic [IW-1:0] pkt_len(input logic [7:0] op);
    logic [3:0] n;
    n = 4'd0;
    case (op[7:4])
      4'h0: n = (op == 8'h02) ? 4'd2 : 4'd0;
      4'h2: case (op[3:2]) 2'd0: n = 4'd3; 2'd1: n = 4'd6; 2'd2: n = 4'd4; default: n = 4'd8; endcase
      4'h3: case (op[3:2]) 2'd0: n = 4'd5; 2'd1: n = 4'd8; 2'd2: n = 4'd7; default: n = 4'd11; endcase
      4'h4: case (op[3:2]) 2'd0: n = 4'd2; 2'd1: n = 4'd0; default: n = 4'd3; endcase
      4'h5: case (op[3:2]) 2'd0: n = 4'd3; 2'd1: n = 4'd0; default: n = 4'd4; endcase
      4'h6: case (op[3:2]) 2'd0: n = 4'd2; 2'd1: n = 4'd3; 2'd2: n = 4'd1; default: n = 4'd2; endcase
      4'h7: n = op[2] ? 4'd2 : 4'd1;
      4'h8: n = (op == 8'h80) ? 4'd3 : 4'd0;
      4'hA: n = (op == 8'hA0) ? 4'd2 : 4'd0;
      4'hC: n = (op == 8'hC0) ? 4'd2 : 4'd0;
      default: n = 4'd0;
    endcase
    return IW'(n) + IW'(1);
  endfunction

  assign in_ready    = xfer_active | (state == COLLECT && !xfer_start);
  assign take        = in_valid && in_ready && !xfer_active;
  assign cur_op      = (cnt == '0) ? in_data[31:24] : op_q;
  assign cur_len     = (cnt == '0) ? pkt_len(in_data[31:24]) : len_q;
  assign done        = take && (cnt == cur_len - IW'(1));

  assign xfer_wvalid = in_valid && xfer_active;
  assign xfer_wdata  = in_data;

  assign pkt_valid   = (state == EMIT);
  assign pkt_data    = pkt_mem[rd];
  assign pkt_last    = (rd == len_q - IW'(1));

  for (genvar g = 0; g < ENV_N; g++) begin : g_env
    assign env_flat[g*32 +: 32] = env_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= COLLECT;
      cnt        <= '0;
      rd         <= '0;
      len_q      <= '0;
      op_q       <= '0;
      status     <= '0;
      dirty      <= 1'b0;
      xfer_start <= 1'b0;
      xfer_read  <= 1'b0;
      xfer_pos   <= '0;
      xfer_size  <= '0;
      for (int i = 0; i < ENV_N; i++) env_q[i] <= '0;
    end else begin
      xfer_start <= 1'b0;
      if (take) begin
        pkt_mem[cnt] <= in_data;
        if (cnt == '0) begin
          op_q  <= in_data[31:24];
          len_q <= cur_len;
        end
        if (done) begin
          cnt <= '0;
          if ((cur_op & 8'hF4) == 8'h24)      status[8:0]   <= pkt_mem[4][8:0];
          else if ((cur_op & 8'hF4) == 8'h34) status[8:0]   <= pkt_mem[5][8:0];
          else if (cur_op == 8'hE1)           status[10:0]  <= in_data[10:0];
          else if (cur_op == 8'hE6)           status[12:11] <= in_data[1:0];
          if (cur_op[7:3] == 5'b11100) env_q[cur_op[2:0]] <= in_data;
          if (cur_op >= 8'h02 && cur_op < 8'hC0) dirty <= 1'b1;
          if (cur_op == 8'hA0 || cur_op == 8'hC0) begin
            xfer_start <= 1'b1;
            xfer_read  <= (cur_op == 8'hC0);
            xfer_pos   <= pkt_mem[1];
            xfer_size  <= in_data;
          end else begin
            state <= EMIT;
            rd    <= '0;
          end
        end else begin
          cnt <= cnt + IW'(1);
        end
      end
      if (state == EMIT && pkt_ready) begin
        if (pkt_last) begin
          state <= COLLECT;
          rd    <= '0;
        end else begin
          rd <= rd + IW'(1);
        end
      end
    end
  end

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_data) && $stable(pkt_last));

  // R2
  emit_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pkt_valid) |-> $past(in_valid && in_ready && !xfer_active));

  // R6
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> !xfer_start);

  // R6
  start_no_emit_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> !pkt_valid);

  // R7
  dirty_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    dirty |=> dirty);

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> status == '0 && !dirty && !pkt_valid && env_flat == '0);
endmodule

// File: tb/test_gpu_cmd_parser.sv
module test_gpu_cmd_parser;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1;
  logic in_valid = 0, pkt_ready = 0, xfer_active = 0;
  logic [31:0] in_data = '0;
  logic in_ready, pkt_valid, pkt_last, xfer_wvalid, xfer_start, xfer_read, dirty;
  logic [31:0] pkt_data, xfer_wdata, xfer_pos, xfer_size;
  logic [12:0] status;
  logic [255:0] env_flat;

  gpu_cmd_parser i_gpu_cmd_parser (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_last(pkt_last), .pkt_ready(pkt_ready),
    .xfer_active(xfer_active), .xfer_wvalid(xfer_wvalid), .xfer_wdata(xfer_wdata),
    .xfer_start(xfer_start), .xfer_read(xfer_read), .xfer_pos(xfer_pos), .xfer_size(xfer_size),
    .status(status), .dirty(dirty), .env_flat(env_flat));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0, drop_act = 0;
  int rem = 0;

  logic [31:0] exp_q[$];
  bit          exp_last[$];
  logic [31:0] xp_pos[$], xp_size[$];
  bit          xp_rd[$];

  logic [31:0] m_buf[12];
  int          m_cnt = 0, m_len = 0;
  logic [12:0] m_status = '0;
  bit          m_dirty = 0;
  logic [31:0] m_env[8];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int tbl_len(input logic [7:0] op);
    case (op) inside
      8'h02: return 3;
      [8'h20:8'h23]: return 4;  [8'h24:8'h27]: return 7;
      [8'h28:8'h2B]: return 5;  [8'h2C:8'h2F]: return 9;
      [8'h30:8'h33]: return 6;  [8'h34:8'h37]: return 9;
      [8'h38:8'h3B]: return 8;  [8'h3C:8'h3F]: return 12;
      [8'h40:8'h43]: return 3;  [8'h48:8'h4F]: return 4;
      [8'h50:8'h53]: return 4;  [8'h58:8'h5F]: return 5;
      [8'h60:8'h63]: return 3;  [8'h64:8'h67]: return 4;
      [8'h68:8'h6B]: return 2;  [8'h6C:8'h6F]: return 3;
      [8'h70:8'h73]: return 2;  [8'h74:8'h77]: return 3;
      [8'h78:8'h7B]: return 2;  [8'h7C:8'h7F]: return 3;
      8'h80: return 4;
      8'hA0, 8'hC0: return 3;
      default: return 1;
    endcase
  endfunction

  task automatic model_word(input logic [31:0] w);
    logic [7:0] op;
    if (m_cnt == 0) m_len = tbl_len(w[31:24]);
    m_buf[m_cnt] = w;
    m_cnt++;
    if (m_cnt == m_len) begin
      op = m_buf[0][31:24];
      if ((op & 8'hF4) == 8'h24) m_status[8:0] = m_buf[4][8:0];
      else if ((op & 8'hF4) == 8'h34) m_status[8:0] = m_buf[5][8:0];
      else if (op == 8'hE1) m_status[10:0] = w[10:0];
      else if (op == 8'hE6) m_status[12:11] = w[1:0];
      if (op >= 8'hE0 && op <= 8'hE7) m_env[op[2:0]] = w;
      if (op >= 8'h02 && op <= 8'hBF) m_dirty = 1;
      if (op == 8'hA0 || op == 8'hC0) begin
        xp_pos.push_back(m_buf[1]); xp_size.push_back(w); xp_rd.push_back(op == 8'hC0);
      end else begin
        for (int i = 0; i < m_len; i++) begin
          exp_q.push_back(m_buf[i]); exp_last.push_back(i == m_len - 1);
        end
      end
      m_cnt = 0;
    end
  endtask

  task automatic send(input logic [31:0] w);
    in_valid = 0;
    forever begin
      @(negedge clk); #1;
      if (drop_act) begin xfer_active = 0; drop_act = 0; end
      if (in_ready && ($urandom % 5 != 0)) break;
    end
    in_valid = 1; in_data = w;
    if (xfer_active) begin
      #1 check(xfer_wvalid && xfer_wdata == w, "R8 write word routed", {31'b0, xfer_wvalid, xfer_wdata}, {32'h1, w});
      rem--;
      if (rem == 0) drop_act = 1;
    end else model_word(w);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while ((exp_q.size() != 0 || !in_ready) && n < 2000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic check_state(input string tag);
    check(status == m_status, {"R3 R4 status ", tag}, 64'(status), 64'(m_status));
    check(dirty == m_dirty, {"R7 dirty ", tag}, 64'(dirty), 64'(m_dirty));
    for (int k = 0; k < 8; k++)
      check(env_flat[k*32 +: 32] == m_env[k], {"R5 env ", tag}, 64'(env_flat[k*32 +: 32]), 64'(m_env[k]));
  endtask

  task automatic send_pkt(input logic [7:0] op, input int wsize);
    int n;
    logic [31:0] sz;
    n = tbl_len(op);
    send({op, 24'($urandom)});
    for (int i = 1; i < n; i++) begin
      if ((op == 8'hA0 || op == 8'hC0) && i == 2) begin
        sz = {$urandom % 65536, 16'(wsize)};
        if (op == 8'hC0) sz = $urandom;
        send(sz[31:0]);
      end else send($urandom);
    end
    if (op == 8'hA0) for (int i = 0; i < wsize; i++) send($urandom);
  endtask

  task automatic do_reset();
    rst = 1; in_valid = 0; xfer_active = 0; drop_act = 0; rem = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    m_cnt = 0; m_status = '0; m_dirty = 0;
    for (int k = 0; k < 8; k++) m_env[k] = '0;
    exp_q.delete(); exp_last.delete(); xp_pos.delete(); xp_size.delete(); xp_rd.delete();
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      pkt_ready = ($urandom % 3 != 0);
      if (pkt_valid && pkt_ready) begin
        if (exp_q.size() == 0) check(0, "R1 unexpected packet word", 64'(pkt_data), 64'hx);
        else begin
          check(pkt_data == exp_q[0] && pkt_last == exp_last[0], "R1 packet word",
                {31'b0, pkt_last, pkt_data}, {31'b0, exp_last[0], exp_q[0]});
          void'(exp_q.pop_front()); void'(exp_last.pop_front());
        end
      end
      if (xfer_start) begin
        if (xp_pos.size() == 0) check(0, "R6 unexpected transfer start", 64'(xfer_pos), 64'hx);
        else begin
          check(xfer_pos == xp_pos[0] && xfer_size == xp_size[0] && xfer_read == xp_rd[0],
                "R6 transfer words", {xfer_pos, xfer_size}, {xp_pos[0], xp_size[0]});
          void'(xp_pos.pop_front()); void'(xp_size.pop_front()); void'(xp_rd.pop_front());
        end
        if (!xfer_read) begin xfer_active = 1; rem = 32'(xfer_size[15:0]); end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit stay_low;
    int r;
    void'($urandom(1234));
    do_reset();
    // R9 reset state
    check(!pkt_valid && status == 0 && !dirty && env_flat == '0 && in_ready, "R9 reset state",
          {pkt_valid, dirty, in_ready}, 64'h1);

    // R4 R5 R7: E1 / E6 outside dirty range
    send(32'hE1123456); wait_idle();
    check(status[10:0] == 11'h456, "R4 E1 status", 64'(status), 64'h456);
    check(!dirty, "R7 E1 leaves dirty clear", 64'(dirty), 0);
    check(env_flat[63:32] == 32'hE1123456, "R5 env1", 64'(env_flat[63:32]), 64'hE1123456);
    send(32'hE6000003); wait_idle();
    check(status[12:11] == 2'd3, "R4 E6 status", 64'(status), 64'h1C56);
    check_state("after env ops");

    // R2 hold partial packet
    send(32'h2C000001); send(32'h11); send(32'h22);
    stay_low = 1;
    repeat (20) begin @(negedge clk); if (pkt_valid) stay_low = 0; end
    check(stay_low, "R2 partial packet held", 64'(!stay_low), 0);
    for (int i = 0; i < 6; i++) send(32'h100 + i);
    wait_idle();
    check(dirty, "R7 dirty set by 0x2C", 64'(dirty), 1);

    // R3 textured families
    send(32'h24000000); for (int i = 1; i < 7; i++) send(i == 4 ? 32'hFFFF_F1AB : 32'h0);
    wait_idle();
    check(status[8:0] == 9'h1AB, "R3 fifth word", 64'(status[8:0]), 64'h1AB);
    send(32'h36000000); for (int i = 1; i < 9; i++) send(i == 5 ? 32'h0000_0055 : 32'hFFFF_FFFF);
    wait_idle();
    check(status[8:0] == 9'h055, "R3 sixth word", 64'(status[8:0]), 64'h55);

    // R6 R8 write transfer then resume with a 0x60 packet; read transfer
    send_pkt(8'hA0, 3); send_pkt(8'h60, 0); wait_idle();
    check(!xfer_active && xp_pos.size() == 0, "R8 transfer finished, parse resumed", 64'(xp_pos.size()), 0);
    send_pkt(8'hC0, 0); send_pkt(8'hE3, 0); wait_idle();
    check_state("after transfers");

    // random mix
    for (int p = 0; p < 400; p++) begin
      r = $urandom % 20;
      if (r < 3) send_pkt(8'hA0, 1 + $urandom % 4);
      else if (r < 4) send_pkt(8'hC0, 0);
      else if (r < 9) send_pkt(8'hE0 + 8'($urandom % 8), 0);
      else send_pkt(8'($urandom), 0);
      if (p % 20 == 19) begin wait_idle(); check_state("random"); end
    end
    wait_idle();
    check_state("random end");
    check(exp_q.size() == 0 && xp_pos.size() == 0, "R1 R6 all expected output seen",
          64'(exp_q.size() + xp_pos.size()), 0);

    // R9 reset mid-packet clears parse state
    send(32'h28000000); send(32'h1);
    do_reset();
    check(!pkt_valid && status == 0 && !dirty && env_flat == '0, "R9 mid-packet reset",
          {pkt_valid, dirty}, 0);
    send_pkt(8'h20, 0); send_pkt(8'hE7, 0); wait_idle();
    check_state("after reset");
    check(exp_q.size() == 0, "R9 R1 clean framing after reset", 64'(exp_q.size()), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule